// File: doc/BRIEF.md
# Memory-Mapped Serial Flash Read Translator

This block sits between a simple read port and the pins of a serial (SPI) flash. When the mapping switch is on, each single-cycle read strobe becomes one complete flash read transaction. Chip select falls, a read opcode goes out, then the address bytes, then an optional run of dummy clocks, and finally 32 bits of data come back on one lane or on four lanes. The four returned bytes are packed into one little-endian word and handed back with a one-cycle ready pulse.

A single 32-bit setup word sets the shape of every transaction: opcode, address length, dummy length and data lane mode. A second input picks who owns the flash pins. When the switch is off, a separate command-driven engine's pin signals pass straight through. A read strobe that arrives in that state is answered at once with zero and causes no pin activity. The serial clock runs at half the system clock in SPI mode 0: it idles low, the flash samples on the rising edge, and the flash drives on the falling edge.

Top module: `mmap_flash_rd`

## Requirements
- R1: After reset the block is idle: `rsp_ready` is 0, and while the switch is on, `spi_cs_n` is 1 and `spi_sclk` is 0.
- R2: Setup bits [7:0] are the opcode. It is the first thing sent after chip select falls, on `spi_io_out[0]`, most significant bit first, one bit per rising serial clock.
- R3: Setup bits [9:8] hold a code c, and c+1 address bytes follow the opcode (2 gives 3 bytes). They are the low (c+1) bytes of `req_addr`, sent most significant bit first on lane 0.
- R4: The number of dummy clocks after the address is 8 × setup[11:10] plus setup[28:24]. When both are 0, the data phase follows the address with no dummy clocks.
- R5: If setup[13:12] is 3, data is read on four lanes in 8 serial clocks, with `spi_io_in[3]` carrying the most significant bit of each nibble and the high nibble first. Any other value reads on `spi_io_in[1]` alone in 32 clocks, most significant bit first.
- R6: The byte at the requested address lands in `rsp_data[7:0]`, and the bytes at the next three addresses land in bits [15:8], [23:16] and [31:24].
- R7: Chip select stays low from the first opcode clock through the last data clock. It rises after the last data bit, and `rsp_ready` pulses for one cycle in the cycle after the first cycle with chip select high.
- R8: A strobe on `req_valid` while `cfg_switch` is 0 and the block is idle gives `rsp_ready`=1 and `rsp_data`=0 in the next cycle, with no chip select activity.
- R9: While `cfg_switch` is 0 and no transaction is in flight, the `spi_*` outputs equal the `eng_*` inputs. A transaction that is in flight keeps the pins until it completes, even if the switch is cleared.
- R10: A strobe that arrives while a transaction is in flight is ignored: it causes no second transaction and no second ready pulse.
- R11: Setup bits [15:14], [23:16] and [31:29] have no effect on the transaction or on the returned data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_setup | input | 32 | Transaction setup word |
| cfg_switch | input | 1 | 1 hands the pins to the translator |
| req_valid | input | 1 | Single-cycle read strobe |
| req_addr | input | ADDR_W | Byte address of the read |
| rsp_ready | output | 1 | One-cycle completion pulse |
| rsp_data | output | 32 | Little-endian read word, valid with rsp_ready |
| eng_sclk | input | 1 | Command engine serial clock |
| eng_cs_n | input | 1 | Command engine chip select |
| eng_io_out | input | 4 | Command engine lane outputs |
| eng_io_oe | input | 4 | Command engine lane output enables |
| spi_sclk | output | 1 | Flash serial clock |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_io_out | output | 4 | Flash lane outputs |
| spi_io_oe | output | 4 | Flash lane output enables |
| spi_io_in | input | 4 | Flash lane inputs |

## Verification
The hardest situations to reach from the ports are events that land in the middle of a long serial sequence: a second strobe, or the switch being cleared, while chip select is low. The bench has a single wait loop for each read. That loop injects either disturbance at a fixed cycle offset into the transaction. The bench then confirms three things: exactly one chip-select fall and one ready pulse occurred, the data came from the first address, and the pins returned to the engine only afterwards. A flash model in the bench decodes opcode and address from the pins and drives data from a computed memory pattern, which covers the dummy-length and lane-mode combinations.

// File: rtl/mfr_pkg.sv
`timescale 1ns/1ps
package mfr_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_CMD, S_DUMMY, S_DATA, S_REL, S_DONE
  } seq_state_t;

  // opcode plus (code+1) address bytes, in serial clocks
  function automatic logic [5:0] cmd_bits(input logic [1:0] code);
    return 6'd16 + {1'b0, code, 3'b000};
  endfunction

  // whole dummy bytes plus extra single clocks
  function automatic logic [5:0] dummy_clks(input logic [1:0] dbytes,
                                            input logic [4:0] extra);
    return {1'b0, dbytes, 3'b000} + {1'b0, extra};
  endfunction

  function automatic logic [5:0] data_clks(input logic quad);
    return quad ? 6'd8 : 6'd32;
  endfunction

  // left-justify the used address bytes inside 32 bits
  function automatic logic [31:0] place_addr(input logic [31:0] a,
                                             input logic [1:0] code);
    return a << (5'd8 * (5'd3 - {3'b000, code}));
  endfunction

  function automatic logic [31:0] byte_swap(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

endpackage

// File: rtl/mfr_seq.sv
`timescale 1ns/1ps
module mfr_seq #(
  parameter int ADDR_W = 32  // at most 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       cfg_setup,
  input  logic              switch_on,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        io_in,
  output logic              tr_sclk,
  output logic              tr_cs_n,
  output logic [3:0]        tr_io_out,
  output logic [3:0]        tr_io_oe,
  output logic              busy,
  output logic              rsp_ready,
  output logic [31:0]       rsp_data
);
  import mfr_pkg::*;

  localparam int TX_W = 40;

  seq_state_t        state;
  logic              half;
  logic [5:0]        cnt;
  logic [TX_W-1:0]   tx_sr;
  logic [31:0]       rx_sr;
  logic              quad_q;
  logic [5:0]        dclk_q;

  wire [7:0]  f_op    = cfg_setup[7:0];
  wire [1:0]  f_abyte = cfg_setup[9:8];
  wire [1:0]  f_dbyte = cfg_setup[11:10];
  wire [1:0]  f_mode  = cfg_setup[13:12];
  wire [4:0]  f_extra = cfg_setup[28:24];
  wire [31:0] addr_ext = 32'(req_addr);

  wire idle_now  = (state == S_IDLE);
  wire req_fire  = req_valid && idle_now;
  wire launch    = req_fire && switch_on;
  wire bypass    = req_fire && !switch_on;
  wire active    = (state == S_CMD) || (state == S_DUMMY) || (state == S_DATA);
  wire last_clk  = active && half && (cnt == 6'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      half      <= 1'b0;
      cnt       <= '0;
      tx_sr     <= '0;
      rx_sr     <= '0;
      quad_q    <= 1'b0;
      dclk_q    <= '0;
      rsp_ready <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_ready <= 1'b0;
      case (state)
        S_IDLE: begin
          half <= 1'b0;
          if (launch) begin
            tx_sr  <= {f_op, place_addr(addr_ext, f_abyte)};
            quad_q <= (f_mode == 2'd3);
            dclk_q <= dummy_clks(f_dbyte, f_extra);
            cnt    <= cmd_bits(f_abyte);
            rx_sr  <= '0;
            state  <= S_CMD;
          end else if (bypass) begin
            rsp_ready <= 1'b1;
            rsp_data  <= '0;
          end
        end
        S_CMD, S_DUMMY, S_DATA: begin
          half <= ~half;
          if (half) begin
            if (state == S_DATA)
              rx_sr <= quad_q ? {rx_sr[27:0], io_in} : {rx_sr[30:0], io_in[1]};
            if (state == S_CMD)
              tx_sr <= tx_sr << 1;
            if (cnt == 6'd1) begin
              if (state == S_CMD && dclk_q != 6'd0) begin
                state <= S_DUMMY;
                cnt   <= dclk_q;
              end else if (state != S_DATA) begin
                state <= S_DATA;
                cnt   <= data_clks(quad_q);
              end else begin
                state <= S_REL;
              end
            end else begin
              cnt <= cnt - 6'd1;
            end
          end
        end
        S_REL: begin
          state     <= S_DONE;
          rsp_ready <= 1'b1;
          rsp_data  <= byte_swap(rx_sr);
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign tr_cs_n   = !active;
  assign tr_sclk   = active && half;
  assign tr_io_out = {3'b000, tx_sr[TX_W-1]};
  assign tr_io_oe  = (state == S_CMD) ? 4'b0001 : 4'b0000;
  assign busy      = !idle_now;

  // R7: release is followed one cycle later by the ready pulse
  a_r7_ready_after_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tr_cs_n) |=> rsp_ready);

  // R7: a sequence only starts from an accepted strobe with the switch on
  a_r7_start_from_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tr_cs_n) |-> $past(req_valid && switch_on));

  // R8: bypassed strobe answers zero next cycle and stays deselected
  a_r8_bypass_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && !switch_on) |=> (rsp_ready && rsp_data == 32'd0 && tr_cs_n));

  // R1: no serial clock while deselected
  a_r1_sclk_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    tr_cs_n |-> !tr_sclk);

  // R10: a strobe in flight never produces a chip select edge
  a_r10_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && active && !last_clk) |=> !$fell(tr_cs_n) && !rsp_ready);

endmodule

// File: rtl/mfr_pinmux.sv
`timescale 1ns/1ps
module mfr_pinmux #(
  parameter int LANES = 4
) (
  input  logic             own_tr,
  input  logic             tr_sclk,
  input  logic             tr_cs_n,
  input  logic [LANES-1:0] tr_io_out,
  input  logic [LANES-1:0] tr_io_oe,
  input  logic             eng_sclk,
  input  logic             eng_cs_n,
  input  logic [LANES-1:0] eng_io_out,
  input  logic [LANES-1:0] eng_io_oe,
  output logic             spi_sclk,
  output logic             spi_cs_n,
  output logic [LANES-1:0] spi_io_out,
  output logic [LANES-1:0] spi_io_oe
);
  assign spi_sclk = own_tr ? tr_sclk : eng_sclk;
  assign spi_cs_n = own_tr ? tr_cs_n : eng_cs_n;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign spi_io_out[g] = own_tr ? tr_io_out[g] : eng_io_out[g];
    assign spi_io_oe[g]  = own_tr ? tr_io_oe[g]  : eng_io_oe[g];
  end
endmodule

// File: rtl/mmap_flash_rd.sv
`timescale 1ns/1ps
module mmap_flash_rd #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       cfg_setup,
  input  logic              cfg_switch,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_ready,
  output logic [31:0]       rsp_data,
  input  logic              eng_sclk,
  input  logic              eng_cs_n,
  input  logic [3:0]        eng_io_out,
  input  logic [3:0]        eng_io_oe,
  output logic              spi_sclk,
  output logic              spi_cs_n,
  output logic [3:0]        spi_io_out,
  output logic [3:0]        spi_io_oe,
  input  logic [3:0]        spi_io_in
);
  logic       tr_sclk, tr_cs_n, busy;
  logic [3:0] tr_io_out, tr_io_oe;

  mfr_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .cfg_setup(cfg_setup), .switch_on(cfg_switch),
    .req_valid(req_valid), .req_addr(req_addr), .io_in(spi_io_in),
    .tr_sclk(tr_sclk), .tr_cs_n(tr_cs_n), .tr_io_out(tr_io_out),
    .tr_io_oe(tr_io_oe), .busy(busy), .rsp_ready(rsp_ready), .rsp_data(rsp_data)
  );

  wire own_tr = cfg_switch || busy;

  mfr_pinmux #(.LANES(4)) u_mux (
    .own_tr(own_tr), .tr_sclk(tr_sclk), .tr_cs_n(tr_cs_n),
    .tr_io_out(tr_io_out), .tr_io_oe(tr_io_oe),
    .eng_sclk(eng_sclk), .eng_cs_n(eng_cs_n), .eng_io_out(eng_io_out),
    .eng_io_oe(eng_io_oe), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_io_out(spi_io_out), .spi_io_oe(spi_io_oe)
  );

  // R9: the translator keeps the pins while a transaction is in flight
  a_r9_hold_pins: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cfg_switch) |-> (spi_cs_n == tr_cs_n));
endmodule

// File: tb/sim_mmap_flash_rd.sv
`timescale 1ns/1ps
module sim_mmap_flash_rd;
  localparam real TCLK = 4.0;

  logic clk = 0, rst_n = 0;
  logic [31:0] cfg_setup = 0;
  logic cfg_switch = 0, req_valid = 0;
  logic [31:0] req_addr = 0;
  logic rsp_ready;
  logic [31:0] rsp_data;
  logic eng_sclk = 0, eng_cs_n = 1;
  logic [3:0] eng_io_out = 0, eng_io_oe = 0;
  logic spi_sclk, spi_cs_n;
  logic [3:0] spi_io_out, spi_io_oe;
  logic [3:0] spi_io_in = 0;

  int n_cmp = 0, n_bad = 0;
  int cs_falls = 0, ready_cnt = 0;

  always #(TCLK/2) clk = ~clk;

  mmap_flash_rd #(.ADDR_W(32)) u0 (.*);

  // flash model configuration
  int m_nab = 3, m_ds = 32, m_quad = 0;
  logic [7:0]  f_op;
  logic [31:0] f_addr;
  int f_rise = 0;

  function automatic logic [7:0] mem_byte(input logic [31:0] a);
    return (a[7:0] * 8'd37) ^ a[15:8] ^ a[23:16] ^ 8'h5C;
  endfunction

  always @(negedge spi_cs_n) begin
    cs_falls++;
    f_rise = 0; f_op = 0; f_addr = 0;
  end

  always @(posedge spi_sclk) if (!spi_cs_n) begin
    if (f_rise < 8) f_op = {f_op[6:0], spi_io_out[0]};
    else if (f_rise < 8 + 8*m_nab) f_addr = {f_addr[30:0], spi_io_out[0]};
    f_rise++;
  end

  always @(negedge spi_sclk) if (!spi_cs_n && f_rise >= m_ds) begin : drv
    int k;
    logic [7:0] b;
    k = f_rise - m_ds;
    if (m_quad != 0) begin
      b = mem_byte(f_addr + 32'(k/2));
      #1 spi_io_in = (k % 2 == 0) ? b[7:4] : b[3:0];
    end else begin
      b = mem_byte(f_addr + 32'(k/8));
      #1 spi_io_in = {2'b00, b[7 - (k % 8)], 1'b0};
    end
  end

  always @(posedge clk) if (rsp_ready) ready_cnt++;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // disturb: 0 none, 1 extra strobe mid-flight, 2 clear switch mid-flight
  task automatic do_read(input logic [7:0] op, input logic [1:0] ac, input logic [1:0] dc,
                         input logic [1:0] md, input logic [4:0] ex, input logic [31:0] addr,
                         input logic [31:0] junk, input int disturb, input string tag);
    logic [31:0] am, expw;
    logic p1, p2;
    int falls0, rdy0, i;
    bit got;
    m_nab  = int'(ac) + 1;
    m_quad = (md == 2'd3) ? 1 : 0;
    m_ds   = 8 + 8*m_nab + 8*int'(dc) + int'(ex);
    cfg_setup = {3'b000, ex, 8'h02, 2'b00, md, dc, ac, op} | junk;
    am = (m_nab == 4) ? addr : (addr & ((32'd1 << (8*m_nab)) - 1));
    expw = {mem_byte(am+3), mem_byte(am+2), mem_byte(am+1), mem_byte(am)};
    falls0 = cs_falls; rdy0 = ready_cnt;
    @(negedge clk); req_valid = 1; req_addr = addr;
    @(negedge clk); req_valid = 0;
    p1 = 0; p2 = 0; got = 0;
    for (i = 0; i < 800; i++) begin
      if (rsp_ready) begin got = 1; break; end
      if (i == 10 && disturb == 1) begin req_valid = 1; req_addr = addr ^ 32'h40; end
      if (i == 11) req_valid = 0;
      if (i == 10 && disturb == 2) cfg_switch = 0;
      p2 = p1; p1 = spi_cs_n;
      @(negedge clk);
    end
    check({tag, " R7 ready seen"}, 64'(got), 64'd1);
    check({tag, " R6 data"}, 64'(rsp_data), 64'(expw));
    check({tag, " R2 opcode"}, 64'(f_op), 64'(op));
    check({tag, " R3 address"}, 64'(f_addr), 64'(am));
    check({tag, " R4 R5 clock count"}, 64'(f_rise), 64'(m_ds + (m_quad != 0 ? 8 : 32)));
    check({tag, " R7 cs history"}, {62'd0, p2, p1}, 64'b01);
    check({tag, " R7 cs high at ready"}, 64'(spi_cs_n), 64'd1);
    @(negedge clk);
    check({tag, " R7 single pulse"}, 64'(rsp_ready), 64'd0);
    repeat (4) @(negedge clk);
    check({tag, " R10 one sequence"}, 64'(cs_falls - falls0), 64'd1);
    check({tag, " R10 one ready"}, 64'(ready_cnt - rdy0), 64'd1);
  endtask

  task automatic t_reset();
    check("R1 ready low in reset", 64'(rsp_ready), 64'd0);
    @(negedge clk); rst_n = 1; cfg_switch = 1;
    @(negedge clk);
    check("R1 cs high", 64'(spi_cs_n), 64'd1);
    check("R1 sclk low", 64'(spi_sclk), 64'd0);
    check("R1 ready low", 64'(rsp_ready), 64'd0);
  endtask

  task automatic t_bypass();
    int f0;
    cfg_switch = 0; f0 = cs_falls;
    @(negedge clk); req_valid = 1; req_addr = 32'h55;
    @(negedge clk); req_valid = 0;
    check("R8 ready next cycle", 64'(rsp_ready), 64'd1);
    check("R8 zero data", 64'(rsp_data), 64'd0);
    repeat (6) @(negedge clk);
    check("R8 no cs activity", 64'(cs_falls - f0), 64'd0);
    cfg_switch = 1;
  endtask

  task automatic t_engine_mux();
    cfg_switch = 0; eng_sclk = 1; eng_cs_n = 1; eng_io_out = 4'hA; eng_io_oe = 4'hF;
    @(negedge clk);
    check("R9 engine sclk", 64'(spi_sclk), 64'd1);
    check("R9 engine io", {56'd0, spi_io_oe, spi_io_out}, 64'hFA);
    eng_sclk = 0; eng_io_out = 0; eng_io_oe = 0;
    cfg_switch = 1;
  endtask

  task automatic t_switch_clear();
    do_read(8'h03, 2'd2, 2'd0, 2'd0, 5'd0, 32'h000777, 32'd0, 2, "switch-clear R9");
    eng_cs_n = 1; eng_sclk = 1;
    @(negedge clk);
    check("R9 pins back to engine", 64'(spi_sclk), 64'd1);
    eng_sclk = 0; cfg_switch = 1;
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        t_reset();
        t_bypass();
        t_engine_mux();
        do_read(8'h03, 2'd2, 2'd0, 2'd0, 5'd0, 32'h00123456, 32'd0, 0, "normal R2 R3");
        do_read(8'h0B, 2'd2, 2'd1, 2'd0, 5'd0, 32'h00ABCDE1, 32'd0, 0, "fast R4");
        do_read(8'h6B, 2'd2, 2'd1, 2'd3, 5'd0, 32'h00010203, 32'd0, 0, "quad R5");
        do_read(8'h6B, 2'd3, 2'd0, 2'd3, 5'd5, 32'hC0FFEE12, 32'd0, 0, "quad4 extra R4");
        do_read(8'h13, 2'd0, 2'd3, 2'd1, 5'd31, 32'h0000FF3E, 32'd0, 0, "max dummy R4");
        do_read(8'h03, 2'd2, 2'd0, 2'd0, 5'd0, 32'h00123456, 32'hE0FFC000, 0, "junk R11");
        do_read(8'h0B, 2'd2, 2'd1, 2'd0, 5'd0, 32'h00000100, 32'd0, 1, "busy strobe R10");
        t_switch_clear();
      end
      begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule